// File: doc/BRIEF.md
# All-One-Polynomial Systolic GF(2^m) Multiplier

This block multiplies two elements of the binary extension field GF(2^m). The field is generated by the all-one polynomial x^m + x^(m-1) + ... + x + 1. Operands arrive as m-bit polynomial-basis words, and the block takes one new pair on every clock. After a fixed number of cycles the product appears on the output with its own valid strobe. The block is meant as the arithmetic kernel inside coding or cryptographic datapaths that issue a stream of independent multiplications.

Inside, both operands are extended to m+1 coefficients. Because alpha^(m+1) = 1, multiplying by alpha is just a cyclic rotation of the extended word. Each pipeline stage does three things at once: it ANDs one multiplier bit with the rotated multiplicand, it XORs the previous partial product into a running sum, and it rotates the multiplicand by wiring. A final stage folds the m+1 coefficient result back into m bits.

A parameter picks one of two layouts. The chain layout is a single stage chain. The split layout uses two shorter branches that each handle part of the partial products; a closing adder then combines them, which roughly halves the latency.

Top module: `gfaop_mul`

## Requirements
- R1: When `out_valid` is high, `out_c` equals the field product of the captured `in_a` and `in_b` reduced modulo the all-one polynomial of degree M. Bit j of `in_a`, `in_b` and `out_c` is the coefficient of alpha^j.
- R2: A new operand pair is accepted on every clock while `in_valid` is high. Back-to-back pairs give back-to-back products, and each product depends only on its own pair.
- R3: With LAYOUT = chain, a pair captured on a rising edge shows on the outputs right after the (M+2)th rising edge, counting the capture edge as the first.
- R4: With LAYOUT = split, the same count is M/2+3 edges. The two branch results reach the closing adder on the same cycle.
- R5: Exactly one `out_valid` cycle appears for each accepted pair, in the order accepted, with the same gaps that the input had. Operand values presented while `in_valid` is low create no output.
- R6: `rst_n` is a synchronous, active-low reset. It holds `out_valid` low while asserted and discards every pair in flight, so no product emerges from operands captured before or during reset.
- R7: Corner cases: a zero operand gives zero. The element 1 (value 1) is the identity. alpha times alpha^(M-1) (values 2 and 2^(M-1)) gives all ones, because the coefficient that reaches degree M folds into every lower coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | M | Multiplicand, bit j = coefficient of alpha^j |
| in_b | input | M | Multiplier, bit j = coefficient of alpha^j |
| out_valid | output | 1 | `out_c` holds a product |
| out_c | output | M | Product, bit j = coefficient of alpha^j |

## Verification
A wrong rotation or a misrouted multiplier bit in any stage corrupts the product of every pair that has that bit set. The bench runs every operand pair for M = 4, so such a fault shows up as a wrong `out_c` within one pipeline latency of the first pair it affects. A valid pipeline that is one stage too short or too long, or two branches that are out of step, shows up as a wrong latency count. It also shows up as valid strobes that no longer match the input gap pattern. A stuck or leaking reset shows up as strobes after a mid-stream reset.

// File: rtl/gfaop_pkg.sv
package gfaop_pkg;

   typedef enum logic {
      GFAOP_CHAIN = 1'b0,
      GFAOP_SPLIT = 1'b1
   } gfaop_layout_e;

   // The all-one polynomial of degree m is irreducible iff m+1 is prime
   // and 2 generates the multiplicative group modulo m+1.
   function automatic bit m_is_legal(input int m);
      int p;
      int r;
      p = m + 1;
      if (m < 2) return 1'b0;
      for (int d = 2; d * d <= p; d++) begin
         if (p % d == 0) return 1'b0;
      end
      r = 1;
      for (int k = 1; k < m; k++) begin
         r = (r * 2) % p;
         if (r == 1) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic int pipe_latency(input int m, input gfaop_layout_e lay);
      return (lay == GFAOP_SPLIT) ? (m / 2 + 3) : (m + 2);
   endfunction

endpackage

// File: rtl/gfaop_chain.sv
// One systolic branch: accumulates b_i * alpha^i * A for i in FIRST .. FIRST+NT-1.
// Register stages: NT, plus one closing accumulate stage.
module gfaop_chain #(
   parameter int M     = 4,
   parameter int FIRST = 0,
   parameter int NT    = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [M:0]   a_ext,
   input  logic [M-1:0] b,
   output logic [M:0]   sum,
   output logic         sum_valid
);
   localparam int W = M + 1;

   function automatic logic [M:0] rotl(input logic [M:0] x, input int s);
      logic [M:0] y;
      for (int j = 0; j < W; j++) y[(j + s) % W] = x[j];
      return y;
   endfunction

   logic [W-1:0] a_start;
   logic [W-1:0] a_q   [NT];
   logic [W-1:0] pp_q  [NT];
   logic [W-1:0] acc_q [NT];
   logic [M-1:0] b_q   [NT];
   logic         v_q   [NT];

   assign a_start = rotl(a_ext, FIRST);

   // Datapath: AND, XOR and rotation of one stage each sit behind their own register.
   always_ff @(posedge clk) begin
      pp_q[0]  <= a_start & {W{b[FIRST]}};
      a_q[0]   <= rotl(a_start, 1);
      acc_q[0] <= '0;
      b_q[0]   <= b;
      for (int k = 1; k < NT; k++) begin
         acc_q[k] <= acc_q[k-1] ^ pp_q[k-1];
         pp_q[k]  <= a_q[k-1] & {W{b_q[k-1][FIRST+k]}};
         a_q[k]   <= rotl(a_q[k-1], 1);
         b_q[k]   <= b_q[k-1];
      end
      sum <= acc_q[NT-1] ^ pp_q[NT-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NT; k++) v_q[k] <= 1'b0;
         sum_valid <= 1'b0;
      end else begin
         v_q[0] <= in_valid;
         for (int k = 1; k < NT; k++) v_q[k] <= v_q[k-1];
         sum_valid <= v_q[NT-1];
      end
   end

   generate
      for (genvar k = 1; k < NT; k++) begin : g_chk
         // Rotation keeps the coefficient weight of the multiplicand.
         AST_ROT_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[k] |-> ($countones(a_q[k]) == $past($countones(a_q[k-1]))))
            else $error("rotation changed weight at stage %0d", k); // R1
         // A partial product never holds a coefficient absent from the multiplicand it came from.
         AST_PP_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[k] |-> ((pp_q[k] & ~$past(a_q[k-1])) == '0))
            else $error("partial product outside multiplicand at stage %0d", k); // R1
      end
   endgenerate

endmodule

// File: rtl/gfaop_fold.sv
// Folds an (M+1)-coefficient word back to M bits (alpha^M = sum of lower powers)
// and adds an already folded M-bit addend; one register stage.
module gfaop_fold #(
   parameter int M = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [M:0]   x,
   input  logic [M-1:0] y,
   output logic         out_valid,
   output logic [M-1:0] z
);
   always_ff @(posedge clk) begin
      z <= x[M-1:0] ^ {M{x[M]}} ^ y;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end
endmodule

// File: rtl/gfaop_mul.sv
module gfaop_mul
   import gfaop_pkg::*;
#(
   parameter int            M      = 4,
   parameter gfaop_layout_e LAYOUT = GFAOP_CHAIN
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [M-1:0] in_a,
   input  logic [M-1:0] in_b,
   output logic         out_valid,
   output logic [M-1:0] out_c
);
   localparam int W   = M + 1;
   localparam int H   = M / 2;
   localparam int LN  = M - 1 - H;
   localparam int LAT = pipe_latency(M, LAYOUT);
   localparam int CW  = $clog2(LAT + 1) + 1;

   generate
      if (!m_is_legal(M)) begin : g_bad_m
         $error("M=%0d: all-one polynomial is not irreducible", M);
      end
   endgenerate

   logic [W-1:0] a_ext;
   assign a_ext = {1'b0, in_a};

   generate
      if (LAYOUT == GFAOP_CHAIN) begin : g_chain
         logic [W-1:0] sum;
         logic         sum_v;

         gfaop_chain #(.M(M), .FIRST(0), .NT(M)) u_chain (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_ext(a_ext), .b(in_b),
            .sum(sum), .sum_valid(sum_v));

         gfaop_fold #(.M(M)) u_fold (
            .clk(clk), .rst_n(rst_n), .in_valid(sum_v), .x(sum), .y('0),
            .out_valid(out_valid), .z(out_c));
      end else begin : g_split
         logic [W-1:0] up_sum;
         logic         up_v;
         logic [M-1:0] lo_d;

         // Upper branch: terms 0 .. H.
         gfaop_chain #(.M(M), .FIRST(0), .NT(H + 1)) u_upper (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_ext(a_ext), .b(in_b),
            .sum(up_sum), .sum_valid(up_v));

         if (LN > 0) begin : g_lower
            logic [W-1:0] lo_sum;
            logic         lo_v;
            logic [M-1:0] lo_f;
            logic         lo_fv;
            logic         lo_dv;

            // Lower branch: terms H+1 .. M-1, folded early, then one alignment stage.
            gfaop_chain #(.M(M), .FIRST(H + 1), .NT(LN)) u_lower (
               .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_ext(a_ext), .b(in_b),
               .sum(lo_sum), .sum_valid(lo_v));

            gfaop_fold #(.M(M)) u_lo_fold (
               .clk(clk), .rst_n(rst_n), .in_valid(lo_v), .x(lo_sum), .y('0),
               .out_valid(lo_fv), .z(lo_f));

            always_ff @(posedge clk) lo_d <= lo_f;

            always_ff @(posedge clk) begin
               if (!rst_n) lo_dv <= 1'b0;
               else        lo_dv <= lo_fv;
            end

            AST_BRANCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
               lo_dv == up_v)
               else $error("branches out of step"); // R4
         end else begin : g_no_lower
            assign lo_d = '0;
         end

         // Closing adder merged with the fold of the upper result.
         gfaop_fold #(.M(M)) u_fold (
            .clk(clk), .rst_n(rst_n), .in_valid(up_v), .x(up_sum), .y(lo_d),
            .out_valid(out_valid), .z(out_c));
      end
   endgenerate

   // Pairs in flight, counted from the ports.
   logic [CW-1:0] inflight;
   always_ff @(posedge clk) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + CW'(in_valid) - CW'(out_valid);
   end

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(LAT))
      else $error("more pairs in flight than pipeline stages"); // R5
   AST_NO_ORPHAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != '0))
      else $error("product without accepted pair"); // R5
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !out_valid)
      else $error("valid right after reset"); // R6

endmodule

// File: tb/gfaop_mul_tb.sv
`timescale 1ns/1ps
module gfaop_mul_tb_top;
   localparam int M     = 4;
   localparam int LAT_C = M + 2;
   localparam int LAT_S = M / 2 + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [M-1:0] in_a = '0;
   logic [M-1:0] in_b = '0;
   logic         ov_c, ov_s;
   logic [M-1:0] oc_c, oc_s;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   gfaop_mul #(.M(M), .LAYOUT(gfaop_pkg::GFAOP_CHAIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .out_valid(ov_c), .out_c(oc_c));

   gfaop_mul #(.M(M), .LAYOUT(gfaop_pkg::GFAOP_SPLIT)) dut_split_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .out_valid(ov_s), .out_c(oc_s));

   // Shift-and-add product, then reduction by the all-one polynomial.
   function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
      int prod = 0;
      for (int i = 0; i < M; i++) if (b[i]) prod = prod ^ (int'(a) << i);
      for (int d = 2 * M - 2; d >= M; d--)
         if (prod[d]) prod = prod ^ (((1 << (M + 1)) - 1) << (d - M));
      return prod[M-1:0];
   endfunction

   logic         ev_c [LAT_C];
   logic [M-1:0] ed_c [LAT_C];
   logic         ev_s [LAT_S];
   logic [M-1:0] ed_s [LAT_S];

   task automatic cmp(input string req, input string which, input logic gv, input logic xv,
                      input logic [M-1:0] gd, input logic [M-1:0] xd);
      checks++;
      if (gv !== xv) begin
         errors++;
         $display("FAIL %s %s out_valid actual=%0b expected=%0b", req, which, gv, xv);
      end else if (xv && (gd !== xd)) begin
         errors++;
         $display("FAIL %s %s out_c actual=%h expected=%h", cur_req, which, gd, xd);
      end
   endtask

   // Cycle-by-cycle reference: one expected slot per register stage.
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         for (int k = 0; k < LAT_C; k++) ev_c[k] = 1'b0;
         for (int k = 0; k < LAT_S; k++) ev_s[k] = 1'b0;
         cmp("R6", "chain", ov_c, 1'b0, oc_c, '0);
         cmp("R6", "split", ov_s, 1'b0, oc_s, '0);
      end else begin
         for (int k = LAT_C - 1; k > 0; k--) begin ev_c[k] = ev_c[k-1]; ed_c[k] = ed_c[k-1]; end
         for (int k = LAT_S - 1; k > 0; k--) begin ev_s[k] = ev_s[k-1]; ed_s[k] = ed_s[k-1]; end
         ev_c[0] = in_valid; ed_c[0] = ref_mul(in_a, in_b);
         ev_s[0] = in_valid; ed_s[0] = ref_mul(in_a, in_b);
         cmp("R5", "chain", ov_c, ev_c[LAT_C-1], oc_c, ed_c[LAT_C-1]);
         cmp("R5", "split", ov_s, ev_s[LAT_S-1], oc_s, ed_s[LAT_S-1]);
      end
   end

   task automatic drive(input logic v, input logic [M-1:0] a, input logic [M-1:0] b);
      @(negedge clk);
      in_valid = v; in_a = a; in_b = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, M'(i * 5), M'(i * 3));
   endtask

   task automatic show_summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      int lc;
      int ls;
      // R6: outputs quiet while reset held, with valid asserted at the inputs.
      drive(1'b1, 4'h3, 4'h5);
      repeat (6) @(negedge clk);
      drive(1'b0, '0, '0);
      rst_n = 1'b1;
      idle(LAT_C + 2);

      // R7: zero, identity, and a product that reaches degree M.
      cur_req = "R7";
      drive(1'b1, 4'h0, 4'hF);
      drive(1'b1, 4'hB, 4'h0);
      drive(1'b1, 4'h1, 4'h9);
      drive(1'b1, 4'hD, 4'h1);
      drive(1'b1, 4'h2, 4'h8);
      drive(1'b1, 4'h8, 4'h2);
      idle(LAT_C + 2);

      // R1/R2: every operand pair, one per clock.
      cur_req = "R2";
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) drive(1'b1, M'(a), M'(b));
      idle(LAT_C + 2);

      // R5: gaps in the input stream; operands toggle while not valid.
      cur_req = "R5";
      for (int i = 0; i < 64; i++) drive((i % 3) != 0, M'(i * 7), M'(i * 11 + 1));
      idle(LAT_C + 2);

      // R3 and R4: latency of a lone pair on an idle pipeline.
      cur_req = "R1";
      lc = 0; ls = 0;
      drive(1'b1, 4'h6, 4'hA);
      for (int n = 1; n <= 14; n++) begin
         @(posedge clk); #3;
         if (n == 1) in_valid = 1'b0;
         if (ov_c && lc == 0) lc = n;
         if (ov_s && ls == 0) ls = n;
      end
      checks++;
      if (lc != LAT_C) begin errors++; $display("FAIL R3 chain latency actual=%0d expected=%0d", lc, LAT_C); end
      checks++;
      if (ls != LAT_S) begin errors++; $display("FAIL R4 split latency actual=%0d expected=%0d", ls, LAT_S); end
      idle(4);

      // R6: reset in mid-stream discards pairs in flight.
      for (int i = 0; i < 4; i++) drive(1'b1, M'(i + 9), M'(i + 2));
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
      idle(LAT_C + 3);

      done = 1'b1;
      show_summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         show_summary();
         $finish;
      end
   end

endmodule